// File: doc/BRIEF.md
# Windowed Address Partition Translator

This block sits between a host that sees a fixed, flat virtual address map and a chip whose resources move around. It holds four programmable windows in a fixed order: memory window 0, the register window, memory window 2 and memory window 3. Each window has a 32-bit physical start and a 32-bit size.

In virtual space the windows are packed end to end. Window 0 starts at address 0, and each later window starts where the earlier ones end, so its base is the sum of the sizes of all windows ahead of it. A virtual access that lands inside a window is rebased to that window's physical start plus its offset into the window. The access then goes out on the physical bus one clock later. An access that lands in no window is dropped. It raises a one-cycle miss pulse and reads back as zero.

Top module: `addr_window_xlat`

## Requirements
- R1: After reset every start and size register is zero, no window matches, and `p_req` and `v_miss` are low.
- R2: A configuration write with `cfg_we` high stores `cfg_wdata` into the register chosen by `cfg_sel`. `cfg_sel[2:1]` is the window index (0 memory 0, 1 register window, 2 memory 2, 3 memory 3). `cfg_sel[0]` is 0 for the start and 1 for the size.
- R3: Window 0 covers virtual addresses from 0 up to, but not including, its size. Such an access goes out with `p_addr` = start0 + address.
- R4: The register window covers [size0, size0 + size1). Its physical address is start1 + (address - size0).
- R5: Memory windows 2 and 3 continue contiguously. Window k begins at the sum of the sizes of windows 0 to k-1, and maps to its start plus the offset. The bases are computed without truncation, so a window that begins at or above 2^32 is never reached.
- R6: A window of size 0 matches nothing. Where windows overlap, the lowest-numbered window that matches wins.
- R7: An access outside every window is not forwarded. It gives a `v_miss` pulse of exactly one cycle, one clock after the request, and `v_rdata` is zero in that cycle.
- R8: A translated access appears on `p_req`, `p_we`, `p_addr` and `p_wdata` exactly one clock after `v_req` is sampled, for one cycle.
- R9: While a forwarded read is on the physical bus, `v_rdata` equals `p_rdata` unchanged. At every other time it is zero.
- R10: A configuration write sampled on the same edge as a request does not affect that request. It applies only to requests sampled on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select: window index and start/size |
| cfg_wdata | input | 32 | Configuration write data |
| v_req | input | 1 | Virtual access request |
| v_we | input | 1 | Virtual access is a write |
| v_addr | input | 32 | Virtual address |
| v_wdata | input | 32 | Virtual write data |
| v_rdata | output | 32 | Read data returned to the host |
| v_miss | output | 1 | Pulse: access matched no window |
| p_req | output | 1 | Physical access request |
| p_we | output | 1 | Physical access is a write |
| p_addr | output | 32 | Translated physical address |
| p_wdata | output | 32 | Physical write data |
| p_rdata | input | 32 | Physical read data |

## Verification
The physical request fields and the miss pulse are each due one clock after the edge that samples `v_req`. Read data is due in that same cycle, because it is passed through without a register. A configuration write counts from the edge that samples it, so a request sampled on that same edge must still be translated with the old windows. The bench drives all stimulus on the falling edge. It updates its own window model only after it has predicted the result of the current request. It compares the outputs on the next falling edge, which is the cycle in which they are due.

// File: rtl/addr_window_xlat.sv
module addr_window_xlat #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int NWIN = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [$clog2(NWIN):0]     cfg_sel,
  input  logic [AW-1:0]             cfg_wdata,
  input  logic                      v_req,
  input  logic                      v_we,
  input  logic [AW-1:0]             v_addr,
  input  logic [DW-1:0]             v_wdata,
  output logic [DW-1:0]             v_rdata,
  output logic                      v_miss,
  output logic                      p_req,
  output logic                      p_we,
  output logic [AW-1:0]             p_addr,
  output logic [DW-1:0]             p_wdata,
  input  logic [DW-1:0]             p_rdata
);

  localparam int IW = $clog2(NWIN);
  localparam int BW = AW + IW + 1;

  logic [AW-1:0] win_start [NWIN];
  logic [AW-1:0] win_size  [NWIN];
  logic [BW-1:0] win_base  [NWIN];
  logic [BW-1:0] win_off   [NWIN];
  logic [AW-1:0] win_phys  [NWIN];
  logic [NWIN-1:0] win_hit;

  logic [BW-1:0] addr_ext;
  assign addr_ext = {{(BW-AW){1'b0}}, v_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NWIN; k++) begin
        win_start[k] <= '0;
        win_size[k]  <= '0;
      end
    end else if (cfg_we) begin
      if (cfg_sel[0]) win_size[cfg_sel[IW:1]]  <= cfg_wdata;
      else            win_start[cfg_sel[IW:1]] <= cfg_wdata;
    end
  end

  for (genvar k = 0; k < NWIN; k++) begin : g_win
    if (k == 0) begin : g_first
      assign win_base[k] = '0;
    end else begin : g_next
      assign win_base[k] = win_base[k-1] + {{(BW-AW){1'b0}}, win_size[k-1]};
    end
    assign win_off[k]  = addr_ext - win_base[k];
    assign win_hit[k]  = (addr_ext >= win_base[k]) &&
                         (win_off[k] < {{(BW-AW){1'b0}}, win_size[k]});
    assign win_phys[k] = win_start[k] + win_off[k][AW-1:0];
  end

  logic [AW-1:0] sel_phys;
  always_comb begin
    sel_phys = '0;
    for (int k = NWIN-1; k >= 0; k--)
      if (win_hit[k]) sel_phys = win_phys[k];
  end

  logic any_hit;
  assign any_hit = |win_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_req   <= 1'b0;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      v_miss  <= 1'b0;
    end else begin
      p_req  <= v_req && any_hit;
      v_miss <= v_req && !any_hit;
      if (v_req && any_hit) begin
        p_we    <= v_we;
        p_addr  <= sel_phys;
        p_wdata <= v_wdata;
      end
    end
  end

  assign v_rdata = (p_req && !p_we) ? p_rdata : '0;

  a_r7_miss_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    v_miss |-> !p_req);
  a_r7_miss_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    v_miss |-> $past(v_req));
  a_r8_req_latency: assert property (@(posedge clk) disable iff (!rst_n)
    p_req |-> $past(v_req));
  a_r8_wdata_carried: assert property (@(posedge clk) disable iff (!rst_n)
    (p_req && p_we) |-> (p_wdata == $past(v_wdata)));
  a_r7_miss_single: assert property (@(posedge clk) disable iff (!rst_n)
    (v_miss && !v_req) |=> !v_miss);

endmodule

// File: tb/addr_window_xlat_tb.sv
module addr_window_xlat_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic v_req = 0, v_we = 0;
  logic [31:0] v_addr = '0, v_wdata = '0;
  logic [31:0] v_rdata, p_addr, p_wdata, p_rdata;
  logic v_miss, p_req, p_we;

  int checks = 0, errors = 0;
  longint unsigned m_start [4];
  longint unsigned m_size  [4];

  always #10 clk = ~clk;
  assign p_rdata = p_addr ^ 32'hA5A5_0F0F;

  addr_window_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .v_req(v_req), .v_we(v_we), .v_addr(v_addr), .v_wdata(v_wdata), .v_rdata(v_rdata),
    .v_miss(v_miss), .p_req(p_req), .p_we(p_we), .p_addr(p_addr), .p_wdata(p_wdata),
    .p_rdata(p_rdata));

  task automatic chk(input string tag, input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit cw, input [2:0] cs, input [31:0] cd,
                     input bit rq, input bit we, input [31:0] a, input [31:0] wd);
    bit hit = 0;
    longint unsigned base = 0, pa = 0;
    cfg_we = cw; cfg_sel = cs; cfg_wdata = cd;
    v_req = rq; v_we = we; v_addr = a; v_wdata = wd;
    for (int k = 0; k < 4; k++) begin
      if (!hit && a >= base && a < base + m_size[k]) begin
        hit = 1;
        pa = (m_start[k] + (a - base)) & 64'hFFFF_FFFF;
      end
      base += m_size[k];
    end
    if (cw) begin
      if (cs[0]) m_size[cs[2:1]] = cd; else m_start[cs[2:1]] = cd;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "p_req", p_req, rq && hit);
    chk(tag, "v_miss", v_miss, rq && !hit);
    if (rq && hit) begin
      chk(tag, "p_addr", p_addr, pa);
      chk(tag, "p_we", p_we, we);
      if (we) chk(tag, "p_wdata", p_wdata, wd);
    end
    chk(tag, "v_rdata", v_rdata, (rq && hit && !we) ? (pa ^ 64'hA5A5_0F0F) : 0);
  endtask

  task automatic cfg(input string tag, input [2:0] cs, input [31:0] cd);
    cyc(tag, 1, cs, cd, 0, 0, 0, 0);
  endtask

  task automatic rd(input string tag, input [31:0] a);
    cyc(tag, 0, 0, 0, 1, 0, a, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_start[k] = 0; m_size[k] = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "p_req", p_req, 0);
    chk("R1", "v_miss", v_miss, 0);
    rst_n = 1;
    rd("R1", 32'h0);
    cyc("R1", 0, 0, 0, 0, 0, 0, 0);
    cfg("R2", 3'b000, 32'h1000_0000);
    cfg("R2", 3'b001, 32'h100);
    cfg("R2", 3'b010, 32'h3000_0000);
    cfg("R2", 3'b011, 32'h40);
    cfg("R2", 3'b100, 32'h2000_0000);
    cfg("R2", 3'b101, 32'h80);
    cfg("R2", 3'b110, 32'h4000_0000);
    cfg("R2", 3'b111, 32'h20);
    rd("R3", 32'h0);
    rd("R3", 32'hFF);
    cyc("R8", 0, 0, 0, 1, 1, 32'h10, 32'hDEAD_BEEF);
    rd("R4", 32'h100);
    rd("R4", 32'h13F);
    cyc("R8", 0, 0, 0, 1, 1, 32'h120, 32'h1234_5678);
    rd("R5", 32'h140);
    rd("R5", 32'h1BF);
    rd("R5", 32'h1C0);
    rd("R5", 32'h1DF);
    rd("R7", 32'h1E0);
    cyc("R7", 0, 0, 0, 1, 1, 32'hFFFF_0000, 32'h1);
    cyc("R7", 0, 0, 0, 0, 0, 0, 0);
    rd("R9", 32'h50);
    cfg("R6", 3'b011, 32'h0);
    rd("R6", 32'h100);
    rd("R6", 32'h17F);
    cyc("R10", 1, 3'b001, 32'h200, 1, 0, 32'h150, 0);
    rd("R10", 32'h150);
    cfg("R5", 3'b001, 32'hFFFF_FFFF);
    cfg("R5", 3'b011, 32'h10);
    rd("R5", 32'hFFFF_FFFE);
    rd("R5", 32'hFFFF_FFFF);
    cfg("R6", 3'b001, 32'h0);
    rd("R6", 32'h5);
    for (int i = 0; i < 8; i++) rd("R4", 32'h3 * i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule